// File: doc/BRIEF.md
# SPI Burst Register-Access Target

This block is an SPI target in mode 0: it samples on the rising clock edge and shifts out on the falling edge. It lets a host controller read and write a bank of 32-bit registers or buffer memory over a four-wire serial link. Each transaction begins with a 32-bit header that carries an operation code, a byte start address and a word count. The chip-select window then carries that many 32-bit data words. The address advances by one word (4 bytes) for each data word, so one header can move a whole run of consecutive locations.

The serial inputs are brought into the system clock domain through two-flop synchronisers and handled as sampled edges. The block checks the framing of every transaction when chip select rises. A frame with an unknown operation code, a zero length, or a clock count different from 32 × (1 + length) sets a sticky error flag. On the memory side the block drives a single-cycle request port: a write carries its data in the request cycle, and read data is expected in the cycle after the request.

One word of the address map is kept by the block for its own status. A read of that word returns the error flag in bit 0. A write with bit 0 set clears the flag. Neither access reaches the memory port.

Top module: `spi_burst_slave`

## Requirements
- R1: The header is the first 32 bits after chip select falls, shifted MSB first. The operation code is in bits 31:24, the byte start address in bits 23:8 and the word count in bits 7:0.
- R2: With operation code 0x41, data word k (k = 0 … length−1) is written through the memory port to address start + 4·k. The write is issued only after all 32 bits of that word have been received.
- R3: With operation code 0x61, data word k is read from address start + 4·k. It is presented on `miso` MSB first, with bit 31 valid before the first clock of that word. The word after it is fetched while the current one shifts out.
- R4: An operation code other than 0x41 or 0x61 sets the error flag, and the frame makes no memory access.
- R5: A length field of 0 sets the error flag, and the frame makes no memory access.
- R6: If the number of clock rising edges under chip select differs from 32 × (1 + length), the error flag is set at chip-select rise. Data words beyond the length, and incomplete words, are never written. Complete words inside the length that arrived before the error was seen are still written.
- R7: The error flag is sticky: a later valid frame does not clear it. Address `STAT_ADDR` (default 0xFFFC) is the status word. A read of it returns the flag in bit 0, and a write of it with bit 0 = 1 clears the flag. Status accesses never appear on the memory port.
- R8: `miso_oe` is high only inside a recognised chip-select window and is low while chip select is high.
- R9: A transaction starts only on a falling edge of chip select. Clock edges while chip select is high cause no memory access and no error. After reset, `mem_req`, `miso_oe` and `spi_err` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host, idle low |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| miso_oe | output | 1 | Output enable for `miso` (tri-state when low) |
| mem_req | output | 1 | Memory access request, one cycle per word |
| mem_we | output | 1 | Write qualifier for `mem_req` |
| mem_addr | output | 16 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| spi_err | output | 1 | Sticky framing error flag |

## Verification
The bench goes after the framing boundaries: a frame one word short, one with extra words, one with a clock count that is not a multiple of 32, a zero length and an unknown operation code. A design that counted clocks only by word, or that decoded the header before checking it, would write the extra word into memory or leave the error flag clear. Bursts of three and four words check that the address steps by 4 and that read words come out back to back. A design that fetched the next word too late would shift out stale bits at the first data clock. The status word is read, cleared and read again to check that the flag survives a valid frame, that it is cleared only by its own write, and that status traffic never reaches the memory port. Clocks sent with chip select high check that no transaction starts without a falling edge.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
   localparam int WORD_W = 32;
   localparam int OP_W   = 8;
   localparam int ADDR_W = 16;
   localparam int LEN_W  = 8;
   localparam int IDX_W  = LEN_W + 1;
   localparam int SH     = $clog2(WORD_W);
   localparam int CNT_W  = SH + LEN_W + 1;
   localparam int BYTES  = WORD_W / 8;

   localparam logic [OP_W-1:0] OP_WR = 8'h41;
   localparam logic [OP_W-1:0] OP_RD = 8'h61;

   typedef struct packed {
      logic [OP_W-1:0]   op;
      logic [ADDR_W-1:0] addr;
      logic [LEN_W-1:0]  len;
   } hdr_t;
endpackage

// File: rtl/spi_burst_sync.sv
module spi_burst_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("spi_burst_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("spi_burst_sync: WIDTH must be positive");
   end

   logic [WIDTH-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= '0;
            else        stg[0] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign dout = stg[STAGES-1];
endmodule

// File: rtl/spi_burst_frame.sv
module spi_burst_frame
   import spi_burst_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_rise,
   input  logic              cs_fall,
   input  logic              cs_rise,
   input  logic              sdi,
   output logic              active,
   output hdr_t              hdr,
   output logic              hdr_done,
   output logic              word_done,
   output logic              mid_rise,
   output logic [WORD_W-1:0] word_data,
   output logic [IDX_W-1:0]  word_idx,
   output logic              frame_err
);
   localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(WORD_W - 1);
   localparam logic [CNT_W-1:0] HDR_BITS = CNT_W'(WORD_W);

   logic [CNT_W-1:0]  bit_cnt;
   logic [WORD_W-1:0] rx;
   logic [WORD_W-1:0] rx_nx;
   logic [CNT_W-1:0]  exp_cnt;
   logic              op_ok;
   logic              bad;

   assign rx_nx   = {rx[WORD_W-2:0], sdi};
   assign exp_cnt = (CNT_W'(hdr.len) + CNT_W'(1)) << SH;
   assign op_ok   = (hdr.op == OP_WR) || (hdr.op == OP_RD);
   assign bad     = (bit_cnt != exp_cnt) || !op_ok || (hdr.len == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active    <= 1'b0;
         bit_cnt   <= '0;
         rx        <= '0;
         hdr       <= '0;
         hdr_done  <= 1'b0;
         word_done <= 1'b0;
         mid_rise  <= 1'b0;
         word_data <= '0;
         word_idx  <= '0;
         frame_err <= 1'b0;
      end else begin
         hdr_done  <= 1'b0;
         word_done <= 1'b0;
         mid_rise  <= 1'b0;
         frame_err <= 1'b0;
         if (cs_fall) begin
            active  <= 1'b1;
            bit_cnt <= '0;
         end else if (active && cs_rise) begin
            active    <= 1'b0;
            frame_err <= bad;
         end else if (active && sclk_rise) begin
            rx <= rx_nx;
            if (bit_cnt != '1) bit_cnt <= bit_cnt + CNT_W'(1);
            if (bit_cnt == HDR_LAST) begin
               hdr      <= hdr_t'(rx_nx);
               hdr_done <= 1'b1;
            end else if (bit_cnt >= HDR_BITS) begin
               if (bit_cnt[SH-1:0] == '1) begin
                  word_done <= 1'b1;
                  word_data <= rx_nx;
                  word_idx  <= IDX_W'((bit_cnt >> SH) - CNT_W'(1));
               end else begin
                  mid_rise <= 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/spi_burst_tx.sv
module spi_burst_tx
   import spi_burst_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              rd_go,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [LEN_W-1:0]  len,
   input  logic              word_done,
   input  logic              mid_rise,
   input  logic              sclk_fall,
   input  logic [WORD_W-1:0] rd_data,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              miso_bit
);
   logic              rd_act;
   logic              tag_tx;
   logic              take_tx;
   logic              take_nxt;
   logic              shift_pend;
   logic [WORD_W-1:0] tx;
   logic [WORD_W-1:0] nxt;
   logic [ADDR_W-1:0] fetch_addr;
   logic [IDX_W-1:0]  fetched;
   logic              more;

   assign more     = fetched < IDX_W'(len);
   assign miso_bit = rd_act & tx[WORD_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_act     <= 1'b0;
         tag_tx     <= 1'b0;
         take_tx    <= 1'b0;
         take_nxt   <= 1'b0;
         shift_pend <= 1'b0;
         tx         <= '0;
         nxt        <= '0;
         fetch_addr <= '0;
         fetched    <= '0;
         rd_req     <= 1'b0;
         rd_addr    <= '0;
      end else begin
         rd_req   <= 1'b0;
         take_tx  <= rd_req & tag_tx;
         take_nxt <= rd_req & ~tag_tx;
         if (!active) begin
            rd_act     <= 1'b0;
            shift_pend <= 1'b0;
            tx         <= '0;
         end else if (rd_go) begin
            rd_act     <= 1'b1;
            rd_req     <= 1'b1;
            tag_tx     <= 1'b1;
            rd_addr    <= start_addr;
            fetch_addr <= start_addr + ADDR_W'(BYTES);
            fetched    <= IDX_W'(1);
         end else if (rd_act) begin
            if (take_nxt) nxt <= rd_data;
            if (take_tx || word_done) begin
               tx         <= take_tx ? rd_data : nxt;
               shift_pend <= 1'b0;
               if (more) begin
                  rd_req     <= 1'b1;
                  tag_tx     <= 1'b0;
                  rd_addr    <= fetch_addr;
                  fetch_addr <= fetch_addr + ADDR_W'(BYTES);
                  fetched    <= fetched + IDX_W'(1);
               end
            end else if (mid_rise) begin
               shift_pend <= 1'b1;
            end else if (sclk_fall && shift_pend) begin
               tx         <= {tx[WORD_W-2:0], 1'b0};
               shift_pend <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/spi_burst_slave.sv
module spi_burst_slave
   import spi_burst_pkg::*;
#(
   parameter int                SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] STAT_ADDR   = 16'hFFFC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk,
   input  logic              cs_n,
   input  logic              mosi,
   output logic              miso,
   output logic              miso_oe,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic              spi_err
);
   if (STAT_ADDR[1:0] != 2'b00) begin : g_bad_stat
      $error("spi_burst_slave: STAT_ADDR must be word aligned");
   end
   if ($bits(hdr_t) != WORD_W) begin : g_bad_hdr
      $error("spi_burst_slave: header fields must fill one word");
   end

   logic [2:0] s_lvl;
   logic [1:0] s_prev;
   logic       sclk_rise, sclk_fall, cs_rise, cs_fall;

   spi_burst_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din({sclk, cs_n, mosi}), .dout(s_lvl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) s_prev <= '0;
      else        s_prev <= s_lvl[2:1];
   end

   assign sclk_rise = s_lvl[2] & ~s_prev[1];
   assign sclk_fall = ~s_lvl[2] & s_prev[1];
   assign cs_rise   = s_lvl[1] & ~s_prev[0];
   assign cs_fall   = ~s_lvl[1] & s_prev[0];

   logic              active, hdr_done, word_done, mid_rise, frame_err;
   hdr_t              hdr;
   logic [WORD_W-1:0] word_data;
   logic [IDX_W-1:0]  word_idx;

   spi_burst_frame u_frame (
      .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .cs_fall(cs_fall),
      .cs_rise(cs_rise), .sdi(s_lvl[0]), .active(active), .hdr(hdr),
      .hdr_done(hdr_done), .word_done(word_done), .mid_rise(mid_rise),
      .word_data(word_data), .word_idx(word_idx), .frame_err(frame_err)
   );

   logic              rd_go, rd_req, miso_bit, stat_hit_q;
   logic [ADDR_W-1:0] rd_addr;
   logic [WORD_W-1:0] rd_data;
   logic              err_q;

   assign rd_go   = hdr_done && (hdr.op == OP_RD) && (hdr.len != '0);
   assign rd_data = stat_hit_q ? {{(WORD_W-1){1'b0}}, err_q} : mem_rdata;

   spi_burst_tx u_tx (
      .clk(clk), .rst_n(rst_n), .active(active), .rd_go(rd_go),
      .start_addr(hdr.addr), .len(hdr.len), .word_done(word_done),
      .mid_rise(mid_rise), .sclk_fall(sclk_fall), .rd_data(rd_data),
      .rd_req(rd_req), .rd_addr(rd_addr), .miso_bit(miso_bit)
   );

   logic              wr_frame, word_ok, err_clr, wr_req_q;
   logic [ADDR_W-1:0] word_addr, wr_addr_q;
   logic [WORD_W-1:0] wr_data_q;

   assign wr_frame  = (hdr.op == OP_WR) && (hdr.len != '0);
   assign word_ok   = word_done && wr_frame && (word_idx < IDX_W'(hdr.len));
   assign word_addr = hdr.addr + (ADDR_W'(word_idx) << 2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_req_q   <= 1'b0;
         wr_addr_q  <= '0;
         wr_data_q  <= '0;
         err_clr    <= 1'b0;
         err_q      <= 1'b0;
         stat_hit_q <= 1'b0;
      end else begin
         wr_req_q   <= 1'b0;
         err_clr    <= 1'b0;
         stat_hit_q <= rd_req && (rd_addr == STAT_ADDR);
         if (word_ok) begin
            if (word_addr == STAT_ADDR) begin
               err_clr <= word_data[0];
            end else begin
               wr_req_q  <= 1'b1;
               wr_addr_q <= word_addr;
               wr_data_q <= word_data;
            end
         end
         if (frame_err)    err_q <= 1'b1;
         else if (err_clr) err_q <= 1'b0;
      end
   end

   assign mem_req   = wr_req_q | (rd_req & (rd_addr != STAT_ADDR));
   assign mem_we    = wr_req_q;
   assign mem_addr  = wr_req_q ? wr_addr_q : rd_addr;
   assign mem_wdata = wr_data_q;
   assign miso      = miso_bit;
   assign miso_oe   = active;
   assign spi_err   = err_q;
endmodule

// File: rtl/spi_burst_slave_chk.sv
module spi_burst_slave_chk
   import spi_burst_pkg::*;
#(
   parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hFFFC
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n,
   input logic              miso_oe,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              spi_err,
   input logic              err_clr,
   input logic [OP_W-1:0]   hdr_op,
   input logic [LEN_W-1:0]  hdr_len
);
   logic [3:0] cs_hist;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cs_hist <= '0;
      else        cs_hist <= {cs_hist[2:0], cs_n};
   end

   // R2: a write strobe is only valid together with a request
   a_r2_we_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> mem_req);

   // R4: only a write operation code reaches the memory as a write
   a_r4_write_needs_wr_op: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (hdr_op == OP_WR));

   // R5: a zero-length header never produces a write
   a_r5_write_needs_len: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (hdr_len != '0));

   // R7: the status word stays off the memory port
   a_r7_status_off_port: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr != STAT_ADDR));

   // R7: the error flag drops only after a clear request
   a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(spi_err) && !spi_err) |-> $past(err_clr));

   // R8: output enable is off once chip select has been high for a while
   a_r8_oe_idle: assert property (@(posedge clk) disable iff (!rst_n)
      ((&cs_hist) && cs_n) |-> !miso_oe);
endmodule

bind spi_burst_slave spi_burst_slave_chk #(.STAT_ADDR(STAT_ADDR)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .miso_oe(miso_oe),
   .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
   .spi_err(spi_err), .err_clr(err_clr), .hdr_op(hdr.op), .hdr_len(hdr.len)
);

// File: tb/tb_spi_burst_slave.sv
`timescale 1ns/1ps
module tb_spi_burst_slave;
   localparam int H = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sclk = 1'b0;
   logic        cs_n = 1'b1;
   logic        mosi = 1'b0;
   logic        miso, miso_oe, mem_req, mem_we, spi_err;
   logic [15:0] mem_addr;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata = '0;

   int total = 0;
   int fails = 0;
   int req_cnt = 0;
   logic        oe_mid;
   logic [31:0] bmem [64];
   logic [31:0] tx_words [8];
   logic [31:0] rx_words [8];

   always #2.5 clk = ~clk;

   spi_burst_slave dut (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
      .miso(miso), .miso_oe(miso_oe), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .spi_err(spi_err)
   );

   always @(posedge clk) begin
      if (rst_n && mem_req) begin
         req_cnt <= req_cnt + 1;
         if (mem_we) bmem[mem_addr[7:2]] <= mem_wdata;
         else        mem_rdata <= bmem[mem_addr[7:2]];
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic spi_frame(input logic [31:0] hdr, input int nclk);
      cs_n = 1'b0;
      repeat (H) @(negedge clk);
      for (int i = 0; i < nclk; i++) begin
         int w;
         int b;
         w = (i - 32) / 32;
         b = i % 32;
         if (i < 32)     mosi = hdr[31-i];
         else if (w < 8) mosi = tx_words[w][31-b];
         else            mosi = 1'b0;
         repeat (H) @(negedge clk);
         if (i >= 32 && w < 8) rx_words[w][31-b] = miso;
         if (i == 10) oe_mid = miso_oe;
         sclk = 1'b1;
         repeat (H) @(negedge clk);
         sclk = 1'b0;
      end
      repeat (H) @(negedge clk);
      cs_n = 1'b1;
      repeat (3*H) @(negedge clk);
   endtask

   task automatic clear_err();
      tx_words[0] = 32'h0000_0001;
      spi_frame({8'h41, 16'hFFFC, 8'd1}, 64);
   endtask

   task automatic t_reset();
      chk("R9 reset mem_req", {31'b0, mem_req}, 32'd0);
      chk("R9 reset miso_oe", {31'b0, miso_oe}, 32'd0);
      chk("R9 reset spi_err", {31'b0, spi_err}, 32'd0);
   endtask

   task automatic t_idle_clocks();
      int r0;
      r0 = req_cnt;
      for (int i = 0; i < 64; i++) begin
         mosi = i[0];
         repeat (H) @(negedge clk);
         sclk = 1'b1;
         repeat (H) @(negedge clk);
         sclk = 1'b0;
      end
      repeat (3*H) @(negedge clk);
      chk("R9 no access without cs fall", req_cnt, r0);
      chk("R9 no error without cs fall", {31'b0, spi_err}, 32'd0);
   endtask

   task automatic t_single_write();
      int r0;
      r0 = req_cnt;
      tx_words[0] = 32'hDEAD_BEEF;
      spi_frame({8'h41, 16'h0010, 8'd1}, 64);
      chk("R1 R2 single write data", bmem[4], 32'hDEAD_BEEF);
      chk("R2 single write count", req_cnt - r0, 32'd1);
      chk("R2 no error", {31'b0, spi_err}, 32'd0);
   endtask

   task automatic t_burst_write();
      int r0;
      r0 = req_cnt;
      tx_words[0] = 32'h1111_0001;
      tx_words[1] = 32'h2222_0002;
      tx_words[2] = 32'h3333_0003;
      spi_frame({8'h41, 16'h0020, 8'd3}, 128);
      chk("R2 burst word0", bmem[8], 32'h1111_0001);
      chk("R2 burst word1", bmem[9], 32'h2222_0002);
      chk("R2 burst word2", bmem[10], 32'h3333_0003);
      chk("R2 burst count", req_cnt - r0, 32'd3);
   endtask

   task automatic t_single_read();
      bmem[12] = 32'hA5C3_9617;
      spi_frame({8'h61, 16'h0030, 8'd1}, 64);
      chk("R3 single read", rx_words[0], 32'hA5C3_9617);
   endtask

   task automatic t_burst_read();
      for (int k = 0; k < 4; k++) bmem[16+k] = 32'h8000_0001 ^ (32'h0F0F_1234 * (k + 1));
      spi_frame({8'h61, 16'h0040, 8'd4}, 160);
      for (int k = 0; k < 4; k++)
         chk("R3 burst read word", rx_words[k], 32'h8000_0001 ^ (32'h0F0F_1234 * (k + 1)));
      chk("R8 oe high in frame", {31'b0, oe_mid}, 32'd1);
      chk("R8 oe low when idle", {31'b0, miso_oe}, 32'd0);
   endtask

   task automatic t_bad_op();
      int r0;
      r0 = req_cnt;
      bmem[20] = 32'h0BAD_0BAD;
      tx_words[0] = 32'h1234_5678;
      spi_frame({8'h55, 16'h0050, 8'd1}, 64);
      chk("R4 bad op no access", req_cnt - r0, 32'd0);
      chk("R4 bad op mem kept", bmem[20], 32'h0BAD_0BAD);
      chk("R4 bad op error", {31'b0, spi_err}, 32'd1);
   endtask

   task automatic t_status();
      int r0;
      tx_words[0] = 32'h5555_AAAA;
      spi_frame({8'h41, 16'h0014, 8'd1}, 64);
      chk("R7 valid frame keeps flag", {31'b0, spi_err}, 32'd1);
      r0 = req_cnt;
      spi_frame({8'h61, 16'hFFFC, 8'd1}, 64);
      chk("R7 status read set", rx_words[0], 32'd1);
      clear_err();
      chk("R7 cleared by write", {31'b0, spi_err}, 32'd0);
      spi_frame({8'h61, 16'hFFFC, 8'd1}, 64);
      chk("R7 status read clear", rx_words[0], 32'd0);
      chk("R7 status off port", req_cnt - r0, 32'd0);
   endtask

   task automatic t_len0();
      int r0;
      r0 = req_cnt;
      spi_frame({8'h41, 16'h0060, 8'd0}, 32);
      chk("R5 zero length error", {31'b0, spi_err}, 32'd1);
      chk("R5 zero length no access", req_cnt - r0, 32'd0);
      clear_err();
   endtask

   task automatic t_short();
      bmem[25] = 32'h2525_2525;
      tx_words[0] = 32'hC0DE_0024;
      tx_words[1] = 32'hC0DE_0025;
      spi_frame({8'h41, 16'h0060, 8'd2}, 64);
      chk("R6 short frame error", {31'b0, spi_err}, 32'd1);
      chk("R6 short frame first word", bmem[24], 32'hC0DE_0024);
      chk("R6 short frame second kept", bmem[25], 32'h2525_2525);
      clear_err();
   endtask

   task automatic t_long();
      bmem[29] = 32'h2929_2929;
      tx_words[0] = 32'hFACE_001C;
      tx_words[1] = 32'hFACE_001D;
      tx_words[2] = 32'hFACE_001E;
      spi_frame({8'h41, 16'h0070, 8'd1}, 128);
      chk("R6 long frame error", {31'b0, spi_err}, 32'd1);
      chk("R6 long frame in-length word", bmem[28], 32'hFACE_001C);
      chk("R6 long frame extra not written", bmem[29], 32'h2929_2929);
      clear_err();
   endtask

   task automatic t_odd();
      tx_words[0] = 32'h0DD0_0DD0;
      spi_frame({8'h41, 16'h0080, 8'd1}, 70);
      chk("R6 non-multiple count error", {31'b0, spi_err}, 32'd1);
      clear_err();
      chk("R7 clear after odd frame", {31'b0, spi_err}, 32'd0);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) bmem[i] = 32'hA5A5_0000 ^ (i * 32'h0101_0101);
      for (int i = 0; i < 8; i++) begin
         tx_words[i] = '0;
         rx_words[i] = '0;
      end
      oe_mid = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_idle_clocks();
      t_single_write();
      t_burst_write();
      t_single_read();
      t_burst_read();
      t_bad_op();
      t_status();
      t_len0();
      t_short();
      t_long();
      t_odd();
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule